// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical page address for a two-level paging scheme with 4 KB pages and optional 4 MB pages. A requester presents a virtual address with a write flag and a user flag. It also presents the current paging controls: paging enable, supervisor write protect, large page enable, the directory base and the A20 address mask. The walker then fetches the directory entry and, for a 4 KB page, the table entry through a single 32-bit memory port. It checks presence and protection and writes the accessed and dirty flags back into memory. Finally it reports either a translation or a fault with an error code.

The result is meant to be loaded into a translation cache. Write permission is returned only when the leaf entry is already dirty. Otherwise the page comes back read-only, so the first store to a clean page returns to the walker, which then sets the dirty flag.

Top module: `page_walker`

## Requirements
- R1: With paging disabled, an accepted request returns, in the next cycle, the address with its low 12 bits cleared and ANDed with the A20 mask, with write permission, a 4 KB size and no memory access.
- R2: The directory entry is read at ((base AND 0xFFFFF000) + (vaddr[31:22] × 4)) AND the A20 mask.
- R3: The table entry is read at ((directory entry AND 0xFFFFF000) + (vaddr[21:12] × 4)) AND the A20 mask.
- R4: A directory entry with bit 7 (size) set while large pages are enabled maps 4 MB. The page address is (entry bits 31:22 AND the A20 mask) plus vaddr[21:12] × 4096, and no table entry is read. With large pages disabled, bit 7 is ignored and a 4 KB walk follows.
- R5: An entry at either level with bit 0 (present) clear ends the walk with a fault whose error bit 0 is 0.
- R6: A user access faults with error bit 0 set when the effective entry lacks bit 2 (user), or when it is a write and bit 1 (writable) is clear. For a 4 KB page the effective entry is the AND of both levels; for a 4 MB page it is the directory entry.
- R7: A supervisor write to a non-writable page faults only when write protect is on. Supervisor reads never take a protection fault.
- R8: An entry whose bit 5 (accessed) is clear is written back with it set. On a write access the leaf is also written with bit 6 (dirty) set. For a 4 KB page the directory entry receives only the accessed flag. No write occurs when the needed flags are already set.
- R9: The error code is 3 bits: bit 0 is 1 for a protection fault and 0 for a non-present fault, bit 1 is the write flag, and bit 2 is the user flag.
- R10: The returned write permission is 1 only when the leaf is dirty after any writeback and the protection rules allow a write. It is 0 on a fault.
- R11: The returned physical page address is masked with the A20 mask.
- R12: The memory request holds its address, direction and data until the ready cycle. Each accepted request yields exactly one single-cycle done pulse, and new requests are taken only when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, held until done |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user privilege |
| pg_en | input | 1 | Paging enable |
| wp_en | input | 1 | Supervisor write protect |
| pse_en | input | 1 | Large page enable |
| dir_base | input | 32 | Page directory base |
| a20_mask | input | 32 | Address mask applied to every physical address |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with ready |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Translation failed |
| err_code | output | 3 | Fault error code |
| pa_page | output | 32 | Physical page address |
| page_big | output | 1 | Translation maps a 4 MB page |
| perm_wr | output | 1 | Write permitted for the cached translation |

## Verification
The hardest state to reach from the ports is a walk that must write back an entry while the memory stalls. Here the write data depends on flags latched from an earlier read, and the result depends on the updated leaf rather than the fetched one. The bench's memory model inserts zero to two wait cycles in rotation, and the stimulus table places clean, accessed-only and dirty entries at both levels under read and write accesses. Each walk's read addresses, write data and result are compared with values worked out from the requirements. Two further runs drive an A20 mask against a base and entry that carry bit 20, which shows the mask on the table addresses and on the result.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_DIR_RD,
      WS_DIR_WB,
      WS_TBL_RD,
      WS_TBL_WB,
      WS_RESP
   } walk_state_e;

   // entry flag positions decoded by the walker
   localparam int unsigned EB_PRESENT = 0;
   localparam int unsigned EB_WRITE   = 1;
   localparam int unsigned EB_USER    = 2;
   localparam int unsigned EB_ACCESS  = 5;
   localparam int unsigned EB_DIRTY   = 6;
   localparam int unsigned EB_SIZE    = 7;

   // error code fields
   localparam int unsigned ERR_W      = 3;
   localparam int unsigned EC_PROT    = 0;
   localparam int unsigned EC_WRITE   = 1;
   localparam int unsigned EC_USER    = 2;

endpackage

// File: rtl/pw_addr_calc.sv
module pw_addr_calc #(
   parameter int unsigned AW         = 32,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned IDX_W      = 10
) (
   input  logic [AW-1:0]            dir_base,
   input  logic [AW-1:0]            dir_entry,
   input  logic [AW-PAGE_SHIFT-1:0] vpn,
   input  logic [AW-1:0]            a20_mask,
   output logic [AW-1:0]            dir_addr,
   output logic [AW-1:0]            tbl_addr
);
   localparam int unsigned VPN_W = AW - PAGE_SHIFT;
   localparam logic [AW-1:0] FRAME_MASK = {{VPN_W{1'b1}}, {PAGE_SHIFT{1'b0}}};

   logic [AW-1:0] dir_off;
   logic [AW-1:0] tbl_off;

   assign dir_off  = {{(AW-IDX_W-2){1'b0}}, vpn[VPN_W-1 -: IDX_W], 2'b00};
   assign tbl_off  = {{(AW-IDX_W-2){1'b0}}, vpn[IDX_W-1:0], 2'b00};

   assign dir_addr = ((dir_base  & FRAME_MASK) + dir_off) & a20_mask;
   assign tbl_addr = ((dir_entry & FRAME_MASK) + tbl_off) & a20_mask;

endmodule

// File: rtl/pw_leaf_eval.sv
module pw_leaf_eval
   import page_walker_pkg::*;
#(
   parameter int unsigned AW            = 32,
   parameter int unsigned PAGE_SHIFT    = 12,
   parameter int unsigned IDX_W         = 10,
   parameter bit          LARGE_PAGE_EN = 1'b1
) (
   input  logic [AW-1:0]            dir_entry,
   input  logic [AW-1:0]            tbl_entry,
   input  logic [AW-PAGE_SHIFT-1:0] vpn,
   input  logic                     is_write,
   input  logic                     is_user,
   input  logic                     wp_en,
   input  logic                     pse_en,
   input  logic [AW-1:0]            a20_mask,
   output logic                     is_big,
   output logic                     prot_fault,
   output logic                     leaf_wb_need,
   output logic [AW-1:0]            leaf_wb_data,
   output logic                     perm_wr,
   output logic [AW-1:0]            pa_page
);
   localparam int unsigned VPN_W    = AW - PAGE_SHIFT;
   localparam int unsigned BIG_SHIFT = PAGE_SHIFT + IDX_W;
   localparam logic [AW-1:0] FRAME_MASK = {{VPN_W{1'b1}}, {PAGE_SHIFT{1'b0}}};
   localparam logic [AW-1:0] BIG_MASK   = {{(AW-BIG_SHIFT){1'b1}}, {BIG_SHIFT{1'b0}}};
   localparam logic [AW-1:0] ACC_BIT    = AW'(1) << EB_ACCESS;
   localparam logic [AW-1:0] DRT_BIT    = AW'(1) << EB_DIRTY;

   logic [AW-1:0] leaf;
   logic [AW-1:0] eff;
   logic [AW-1:0] leaf_new;
   logic [AW-1:0] va_page;
   logic [AW-1:0] pa_small;
   logic [AW-1:0] pa_large;
   logic          wr_allowed;

   generate
      if (LARGE_PAGE_EN) begin : g_large
         assign is_big = dir_entry[EB_SIZE] & pse_en;
      end else begin : g_small_only
         assign is_big = 1'b0;
      end
   endgenerate

   assign leaf     = is_big ? dir_entry : tbl_entry;
   assign eff      = is_big ? dir_entry : (dir_entry & tbl_entry);
   assign leaf_new = leaf | ACC_BIT | (is_write ? DRT_BIT : '0);

   assign wr_allowed   = is_user ? eff[EB_WRITE] : (!wp_en || eff[EB_WRITE]);
   assign prot_fault   = is_user ? (!eff[EB_USER] || (is_write && !eff[EB_WRITE]))
                                 : (is_write && wp_en && !eff[EB_WRITE]);
   assign leaf_wb_need = !leaf[EB_ACCESS] || (is_write && !leaf[EB_DIRTY]);
   assign leaf_wb_data = leaf_new;
   assign perm_wr      = leaf_new[EB_DIRTY] && wr_allowed;

   assign va_page  = {vpn, {PAGE_SHIFT{1'b0}}};
   assign pa_small = tbl_entry & FRAME_MASK & a20_mask;
   assign pa_large = (dir_entry & BIG_MASK & a20_mask) + (va_page & ~BIG_MASK);
   assign pa_page  = is_big ? pa_large : pa_small;

endmodule

// File: rtl/page_walker.sv
module page_walker
   import page_walker_pkg::*;
#(
   parameter int unsigned AW            = 32,
   parameter int unsigned PAGE_SHIFT    = 12,
   parameter bit          LARGE_PAGE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [AW-1:0]     req_vaddr,
   input  logic              req_write,
   input  logic              req_user,
   input  logic              pg_en,
   input  logic              wp_en,
   input  logic              pse_en,
   input  logic [AW-1:0]     dir_base,
   input  logic [AW-1:0]     a20_mask,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [AW-1:0]     mem_addr,
   output logic [AW-1:0]     mem_wdata,
   input  logic              mem_ready,
   input  logic [AW-1:0]     mem_rdata,
   output logic              done,
   output logic              fault,
   output logic [ERR_W-1:0]  err_code,
   output logic [AW-1:0]     pa_page,
   output logic              page_big,
   output logic              perm_wr
);
   localparam int unsigned VPN_W = AW - PAGE_SHIFT;
   localparam int unsigned IDX_W = PAGE_SHIFT - 2;
   localparam logic [AW-1:0] FRAME_MASK = {{VPN_W{1'b1}}, {PAGE_SHIFT{1'b0}}};
   localparam logic [AW-1:0] ACC_BIT    = AW'(1) << EB_ACCESS;

   generate
      if (AW != 32 || PAGE_SHIFT != 12) begin : g_bad_geometry
         $error("page_walker: entry layout needs AW=32 and PAGE_SHIFT=12");
      end
      if (VPN_W != 2 * IDX_W) begin : g_bad_levels
         $error("page_walker: two index fields must fill the page number");
      end
   endgenerate

   walk_state_e state_q, state_d;
   logic [AW-1:0] dir_q, tbl_q;
   logic [AW-1:0] dir_cur, tbl_cur;
   logic [AW-1:0] dir_addr, tbl_addr;
   logic [AW-PAGE_SHIFT-1:0] vpn;

   logic          is_big, prot_fault, leaf_wb_need, perm_wr_w;
   logic [AW-1:0] leaf_wb_data, pa_walk, pa_flat;

   logic          res_set, res_fault, res_prot;
   logic          busy;

   logic              fault_q, big_q, pw_q;
   logic [ERR_W-1:0]  err_q;
   logic [AW-1:0]     pa_q;

   assign vpn     = req_vaddr[AW-1:PAGE_SHIFT];
   assign dir_cur = (state_q == WS_DIR_RD) ? mem_rdata : dir_q;
   assign tbl_cur = (state_q == WS_TBL_RD) ? mem_rdata : tbl_q;
   assign pa_flat = req_vaddr & FRAME_MASK & a20_mask;
   assign busy    = (state_q != WS_IDLE);

   pw_addr_calc #(
      .AW         (AW),
      .PAGE_SHIFT (PAGE_SHIFT),
      .IDX_W      (IDX_W)
   ) u_addr (
      .dir_base  (dir_base),
      .dir_entry (dir_q),
      .vpn       (vpn),
      .a20_mask  (a20_mask),
      .dir_addr  (dir_addr),
      .tbl_addr  (tbl_addr)
   );

   pw_leaf_eval #(
      .AW            (AW),
      .PAGE_SHIFT    (PAGE_SHIFT),
      .IDX_W         (IDX_W),
      .LARGE_PAGE_EN (LARGE_PAGE_EN)
   ) u_leaf (
      .dir_entry    (dir_cur),
      .tbl_entry    (tbl_cur),
      .vpn          (vpn),
      .is_write     (req_write),
      .is_user      (req_user),
      .wp_en        (wp_en),
      .pse_en       (pse_en),
      .a20_mask     (a20_mask),
      .is_big       (is_big),
      .prot_fault   (prot_fault),
      .leaf_wb_need (leaf_wb_need),
      .leaf_wb_data (leaf_wb_data),
      .perm_wr      (perm_wr_w),
      .pa_page      (pa_walk)
   );

   // memory port driven from the walk state
   always_comb begin
      mem_valid = 1'b0;
      mem_write = 1'b0;
      mem_addr  = dir_addr;
      mem_wdata = '0;
      unique case (state_q)
         WS_DIR_RD: begin
            mem_valid = 1'b1;
         end
         WS_DIR_WB: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_wdata = is_big ? leaf_wb_data : (dir_q | ACC_BIT);
         end
         WS_TBL_RD: begin
            mem_valid = 1'b1;
            mem_addr  = tbl_addr;
         end
         WS_TBL_WB: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_addr  = tbl_addr;
            mem_wdata = leaf_wb_data;
         end
         default: ;
      endcase
   end

   // next state and result selection
   always_comb begin
      state_d   = state_q;
      res_set   = 1'b0;
      res_fault = 1'b0;
      res_prot  = 1'b0;
      unique case (state_q)
         WS_IDLE: begin
            if (req_valid) begin
               if (pg_en) begin
                  state_d = WS_DIR_RD;
               end else begin
                  state_d = WS_RESP;
                  res_set = 1'b1;
               end
            end
         end
         WS_DIR_RD: begin
            if (mem_ready) begin
               if (!mem_rdata[EB_PRESENT]) begin
                  state_d   = WS_RESP;
                  res_set   = 1'b1;
                  res_fault = 1'b1;
               end else if (is_big) begin
                  if (prot_fault) begin
                     state_d   = WS_RESP;
                     res_set   = 1'b1;
                     res_fault = 1'b1;
                     res_prot  = 1'b1;
                  end else if (leaf_wb_need) begin
                     state_d = WS_DIR_WB;
                  end else begin
                     state_d = WS_RESP;
                     res_set = 1'b1;
                  end
               end else if (!mem_rdata[EB_ACCESS]) begin
                  state_d = WS_DIR_WB;
               end else begin
                  state_d = WS_TBL_RD;
               end
            end
         end
         WS_DIR_WB: begin
            if (mem_ready) begin
               if (is_big) begin
                  state_d = WS_RESP;
                  res_set = 1'b1;
               end else begin
                  state_d = WS_TBL_RD;
               end
            end
         end
         WS_TBL_RD: begin
            if (mem_ready) begin
               if (!mem_rdata[EB_PRESENT]) begin
                  state_d   = WS_RESP;
                  res_set   = 1'b1;
                  res_fault = 1'b1;
               end else if (prot_fault) begin
                  state_d   = WS_RESP;
                  res_set   = 1'b1;
                  res_fault = 1'b1;
                  res_prot  = 1'b1;
               end else if (leaf_wb_need) begin
                  state_d = WS_TBL_WB;
               end else begin
                  state_d = WS_RESP;
                  res_set = 1'b1;
               end
            end
         end
         WS_TBL_WB: begin
            if (mem_ready) begin
               state_d = WS_RESP;
               res_set = 1'b1;
            end
         end
         WS_RESP: begin
            state_d = WS_IDLE;
         end
         default: begin
            state_d = WS_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         dir_q   <= '0;
         tbl_q   <= '0;
         fault_q <= 1'b0;
         err_q   <= '0;
         pa_q    <= '0;
         big_q   <= 1'b0;
         pw_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == WS_DIR_RD && mem_ready) begin
            dir_q <= mem_rdata;
         end
         if (state_q == WS_TBL_RD && mem_ready) begin
            tbl_q <= mem_rdata;
         end
         if (res_set) begin
            fault_q <= res_fault;
            if (res_fault) begin
               err_q[EC_PROT]  <= res_prot;
               err_q[EC_WRITE] <= req_write;
               err_q[EC_USER]  <= req_user;
               pa_q            <= '0;
               big_q           <= 1'b0;
               pw_q            <= 1'b0;
            end else begin
               err_q <= '0;
               pa_q  <= pg_en ? pa_walk : pa_flat;
               big_q <= pg_en && is_big;
               pw_q  <= pg_en ? perm_wr_w : 1'b1;
            end
         end
      end
   end

   assign done     = (state_q == WS_RESP);
   assign fault    = fault_q;
   assign err_code = err_q;
   assign pa_page  = pa_q;
   assign page_big = big_q;
   assign perm_wr  = pw_q;

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_write,
   input logic          req_user,
   input logic          pg_en,
   input logic          busy,
   input logic          mem_valid,
   input logic          mem_write,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] mem_wdata,
   input logic          mem_ready,
   input logic          done,
   input logic          fault,
   input logic [2:0]    err_code,
   input logic [AW-1:0] pa_page,
   input logic          perm_wr
);

   p_flat_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && !pg_en) |=> (done && !fault && perm_wr && !mem_valid));

   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                     && $stable(mem_write) && $stable(mem_wdata)));

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_valid);

   p_err_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (err_code[1] == req_write && err_code[2] == req_user));

   p_wb_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write) |-> mem_wdata[5]);

   p_fault_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> !perm_wr);

   p_page_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> (pa_page[11:0] == 12'h000));

endmodule

bind page_walker pw_checker #(.AW(AW)) u_pw_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_user  (req_user),
   .pg_en     (pg_en),
   .busy      (busy),
   .mem_valid (mem_valid),
   .mem_write (mem_write),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .done      (done),
   .fault     (fault),
   .err_code  (err_code),
   .pa_page   (pa_page),
   .perm_wr   (perm_wr)
);

// File: tb/page_walker_bench.sv
`timescale 1ns/1ps
module page_walker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        pg_en = 1'b0;
   logic        wp_en = 1'b0;
   logic        pse_en = 1'b0;
   logic [31:0] dir_base = '0;
   logic [31:0] a20_mask = '1;
   logic        mem_valid, mem_write, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        done, fault, page_big, perm_wr;
   logic [2:0]  err_code;
   logic [31:0] pa_page;

   always #10 clk = ~clk;

   page_walker u_page_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .pg_en(pg_en), .wp_en(wp_en),
      .pse_en(pse_en), .dir_base(dir_base), .a20_mask(a20_mask),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .done(done), .fault(fault), .err_code(err_code), .pa_page(pa_page),
      .page_big(page_big), .perm_wr(perm_wr)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // memory model with rotating wait states and a preload port
   logic [31:0] mem [0:4095];
   logic        pl_en = 1'b0;
   logic [11:0] pl_idx = '0;
   logic [31:0] pl_data = '0;
   int          wait_left = 0;
   int          acc_seq = 0;
   int          rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
   logic [31:0] rd_log [0:63];
   logic [31:0] wd_log [0:63];
   bit          hs_err = 1'b0;
   bit          prev_wait = 1'b0;
   logic [31:0] prev_addr = '0;
   logic        prev_write = 1'b0;

   assign mem_ready = mem_valid && (wait_left == 0);
   assign mem_rdata = mem[mem_addr[13:2]];

   always @(posedge clk) begin
      if (pl_en) mem[pl_idx] <= pl_data;
      if (mem_valid && mem_ready) begin
         if (mem_write) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            wd_log[wr_cnt % 64] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            rd_log[rd_cnt % 64] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
         end
         acc_seq   <= acc_seq + 1;
         wait_left <= acc_seq % 3;
      end else if (mem_valid) begin
         wait_left <= wait_left - 1;
      end
      if (prev_wait && (!mem_valid || mem_addr != prev_addr || mem_write != prev_write))
         hs_err <= 1'b1;
      prev_wait  <= mem_valid && !mem_ready;
      prev_addr  <= mem_addr;
      prev_write <= mem_write;
      if (done) done_cnt <= done_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic poke(input logic [31:0] addr, input logic [31:0] data);
      @(negedge clk);
      pl_en = 1'b1; pl_idx = addr[13:2]; pl_data = data;
      @(negedge clk);
      pl_en = 1'b0;
   endtask

   task automatic walk(input logic [31:0] va, input bit w, input bit u,
                       output bit f, output logic [2:0] e, output logic [31:0] pa,
                       output bit pw, output bit bg, output int nrd, output int nwr,
                       output int ndone, output logic [31:0] ra0,
                       output logic [31:0] ra1, output logic [31:0] wd0);
      int rd0, wr0, dn0;
      bit seen;
      rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt; seen = 1'b0;
      f = 1'b0; e = '0; pa = '0; pw = 1'b0; bg = 1'b0;
      @(negedge clk);
      req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
      for (int c = 0; c < 200 && !seen; c++) begin
         @(negedge clk);
         if (done) begin
            seen = 1'b1;
            f = fault; e = err_code; pa = pa_page; pw = perm_wr; bg = page_big;
         end
      end
      req_valid = 1'b0;
      chk(seen, "R12", "walk completion", 32'(seen), 32'h1);
      @(negedge clk);
      @(negedge clk);
      nrd = rd_cnt - rd0; nwr = wr_cnt - wr0; ndone = done_cnt - dn0;
      ra0 = rd_log[rd0 % 64]; ra1 = rd_log[(rd0 + 1) % 64]; wd0 = wd_log[wr0 % 64];
   endtask

   typedef struct packed {
      logic [31:0] pde;
      logic [31:0] pte;
      logic        pg, wp, pse, wr, us;
      logic        x_fault;
      logic [2:0]  x_err;
      logic [31:0] x_pa;
      logic        x_pw;
      logic        x_big;
      logic [1:0]  x_nrd;
      logic [1:0]  x_nwr;
      logic [31:0] x_wd;
   } vec_t;

   localparam int NV = 18;
   localparam logic [31:0] VA = 32'h00C0_5123;
   localparam vec_t VEC [NV] = '{
      '{32'h00002027, 32'h00555067, 1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,3'd0, 32'h00555000, 1'b1,1'b0, 2'd2,2'd0, 32'h0},
      '{32'h00002027, 32'h00555047, 1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,3'd0, 32'h00555000, 1'b1,1'b0, 2'd2,2'd1, 32'h00555067},
      '{32'h00002027, 32'h00555027, 1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,3'd0, 32'h00555000, 1'b0,1'b0, 2'd2,2'd0, 32'h0},
      '{32'h00002027, 32'h00555027, 1'b1,1'b0,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h00555000, 1'b1,1'b0, 2'd2,2'd1, 32'h00555067},
      '{32'h00002007, 32'h00555067, 1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,3'd0, 32'h00555000, 1'b1,1'b0, 2'd2,2'd1, 32'h00002027},
      '{32'h00002026, 32'h00555067, 1'b1,1'b0,1'b0,1'b0,1'b1, 1'b1,3'd4, 32'h0, 1'b0,1'b0, 2'd1,2'd0, 32'h0},
      '{32'h00002027, 32'h00555066, 1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1,3'd6, 32'h0, 1'b0,1'b0, 2'd2,2'd0, 32'h0},
      '{32'h00002023, 32'h00555067, 1'b1,1'b0,1'b0,1'b0,1'b1, 1'b1,3'd5, 32'h0, 1'b0,1'b0, 2'd2,2'd0, 32'h0},
      '{32'h00002027, 32'h00555065, 1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1,3'd7, 32'h0, 1'b0,1'b0, 2'd2,2'd0, 32'h0},
      '{32'h00002025, 32'h00555067, 1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1,3'd7, 32'h0, 1'b0,1'b0, 2'd2,2'd0, 32'h0},
      '{32'h00002027, 32'h00555065, 1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,3'd0, 32'h00555000, 1'b1,1'b0, 2'd2,2'd0, 32'h0},
      '{32'h00002027, 32'h00555065, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,3'd3, 32'h0, 1'b0,1'b0, 2'd2,2'd0, 32'h0},
      '{32'h00002027, 32'h00555065, 1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0, 32'h00555000, 1'b0,1'b0, 2'd2,2'd0, 32'h0},
      '{32'h0AFFE0E7, 32'h00000000, 1'b1,1'b0,1'b1,1'b0,1'b1, 1'b0,3'd0, 32'h0AC05000, 1'b1,1'b1, 2'd1,2'd0, 32'h0},
      '{32'h0AC000A7, 32'h00000000, 1'b1,1'b0,1'b1,1'b1,1'b1, 1'b0,3'd0, 32'h0AC05000, 1'b1,1'b1, 2'd1,2'd1, 32'h0AC000E7},
      '{32'h000020A7, 32'h00555067, 1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,3'd0, 32'h00555000, 1'b1,1'b0, 2'd2,2'd0, 32'h0},
      '{32'h0AC000E5, 32'h00000000, 1'b1,1'b0,1'b1,1'b1,1'b1, 1'b1,3'd7, 32'h0, 1'b0,1'b0, 2'd1,2'd0, 32'h0},
      '{32'h00002027, 32'h00000000, 1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h00C05000, 1'b1,1'b0, 2'd0,2'd0, 32'h0}
   };

   function automatic string vtag(input int i);
      case (i)
         0, 2:         return "R10";
         1, 3, 4, 14:  return "R8";
         5, 6:         return "R5";
         7, 8, 9:      return "R6";
         10, 11, 12:   return "R7";
         13, 15, 16:   return "R4";
         default:      return "R1";
      endcase
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      bit f, pw, bg;
      logic [2:0] e;
      logic [31:0] pa, ra0, ra1, wd0;
      int nrd, nwr, ndone;
      string tg;

      repeat (3) @(negedge clk);
      // reset state, R12
      chk(!done && !mem_valid, "R12", "reset quiet", {30'h0, done, mem_valid}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !mem_valid, "R12", "idle after reset", {30'h0, done, mem_valid}, 32'h0);

      dir_base = 32'h0000_1000;
      a20_mask = 32'hFFFF_FFFF;
      for (int i = 0; i < NV; i++) begin
         poke(32'h0000_100C, VEC[i].pde);
         poke(32'h0000_2014, VEC[i].pte);
         pg_en = VEC[i].pg; wp_en = VEC[i].wp; pse_en = VEC[i].pse;
         walk(VA, VEC[i].wr, VEC[i].us, f, e, pa, pw, bg, nrd, nwr, ndone, ra0, ra1, wd0);
         tg = vtag(i);
         chk(f == VEC[i].x_fault && (!f || e == VEC[i].x_err), (f || VEC[i].x_fault) ? "R9" : tg,
             $sformatf("vec %0d fault/err", i), {28'h0, f, e}, {28'h0, VEC[i].x_fault, VEC[i].x_err});
         if (!VEC[i].x_fault) begin
            chk(pa == VEC[i].x_pa, tg, $sformatf("vec %0d page", i), pa, VEC[i].x_pa);
            chk(pw == VEC[i].x_pw, "R10", $sformatf("vec %0d write perm", i), 32'(pw), 32'(VEC[i].x_pw));
            chk(bg == VEC[i].x_big, "R4", $sformatf("vec %0d size", i), 32'(bg), 32'(VEC[i].x_big));
         end
         chk(nrd == int'(VEC[i].x_nrd), tg, $sformatf("vec %0d reads", i), 32'(nrd), 32'(VEC[i].x_nrd));
         chk(nwr == int'(VEC[i].x_nwr), "R8", $sformatf("vec %0d writes", i), 32'(nwr), 32'(VEC[i].x_nwr));
         if (VEC[i].x_nwr != 0)
            chk(wd0 == VEC[i].x_wd, "R8", $sformatf("vec %0d wb data", i), wd0, VEC[i].x_wd);
         if (VEC[i].x_nrd != 0)
            chk(ra0 == 32'h0000_100C, "R2", $sformatf("vec %0d dir addr", i), ra0, 32'h0000_100C);
         if (VEC[i].x_nrd == 2 && VEC[i].x_nwr == 0)
            chk(ra1 == 32'h0000_2014, "R3", $sformatf("vec %0d tbl addr", i), ra1, 32'h0000_2014);
         chk(ndone == 1, "R12", $sformatf("vec %0d done pulses", i), 32'(ndone), 32'h1);
      end

      // A20 mask on table addresses and result: R11, R2, R3
      a20_mask = 32'hFFEF_FFFF;
      dir_base = 32'h0010_1000;
      poke(32'h0000_100C, 32'h0010_2027);
      poke(32'h0000_2014, 32'h0075_5067);
      pg_en = 1'b1; wp_en = 1'b0; pse_en = 1'b0;
      walk(VA, 1'b0, 1'b1, f, e, pa, pw, bg, nrd, nwr, ndone, ra0, ra1, wd0);
      chk(ra0 == 32'h0000_100C, "R2", "a20 dir addr", ra0, 32'h0000_100C);
      chk(ra1 == 32'h0000_2014, "R3", "a20 tbl addr", ra1, 32'h0000_2014);
      chk(!f && pa == 32'h0065_5000, "R11", "a20 page", pa, 32'h0065_5000);

      // paging off with A20 masking: R1, R11
      pg_en = 1'b0;
      walk(32'h0010_5123, 1'b1, 1'b0, f, e, pa, pw, bg, nrd, nwr, ndone, ra0, ra1, wd0);
      chk(!f && pa == 32'h0000_5000, "R11", "flat a20 page", pa, 32'h0000_5000);
      chk(nrd == 0 && nwr == 0 && pw, "R1", "flat no access", 32'(nrd + nwr), 32'h0);

      chk(!hs_err, "R12", "request held until ready", 32'(hs_err), 32'h0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule